// File: doc/BRIEF.md
# Streaming 16-point radix-2² FFT

This block computes a 16-point discrete Fourier transform on a continuous stream of complex fixed-point samples. One sample enters on every clock, and a frame-start pulse marks the first sample of each frame. One transform result leaves on every clock. Results come out in bit-reversed bin order, with a pulse on the first result of each frame and a valid flag. Frames can follow each other with no idle cycle between them.

The pipeline has four delay-feedback butterflies with feedback depths 8, 4, 2 and 1. The second and fourth butterflies can also rotate their incoming operand by -j, which is only a swap of the real and imaginary parts and a negation. A general complex multiplier sits only between the second and third butterflies, and it reads a small table of constants. Every butterfly halves its results, with truncation, so the block returns the transform divided by 16. A single 4-bit counter drives all the selects, the rotation enables and the twiddle index.

Top module: `fft16_r22sdf`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid and out_sof are 0 and out_re and out_im are 0.
- R2: Output position k (k = 0..15, counted from out_sof) of a frame carries bin X(b), where b is k with its four bits reversed. X(b) = (1/16)·Σ x(n)·e^(-j2πnb/16).
- R3: An impulse of value A at n = 0, with A a multiple of 16, gives exactly A/16 in every bin. A constant frame gives exactly that constant in bin 0 and exactly 0 in every other bin.
- R4: Inputs whose complex magnitude does not exceed 2^(W-1)-1 never wrap. A full-scale constant frame of (32767, 0) returns exactly (32767, 0) in bin 0.
- R5: The first out_sof is high during the cycle that follows the 15th rising edge after the edge that sampled the frame-start sample.
- R6: out_valid stays 0 until the first result of the first frame is presented, whatever data arrives before the first in_start. It rises together with that first out_sof and then stays 1 until reset.
- R7: With in_start every 16 cycles and no gaps, every frame is transformed correctly, and out_sof pulses exactly once every 16 cycles.
- R8: An impulse at any position, which uses the nontrivial twiddles, is transformed to within 4 LSB of the exact value in each part.
- R9: An alternating frame x(n) = (-1)^n·c gives exactly c in bin 8 (output position 1) and 0 in every other bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | High with the first sample of a frame |
| in_re | input | W | Real part of the input sample, signed |
| in_im | input | W | Imaginary part of the input sample, signed |
| out_re | output | W | Real part of the result, signed |
| out_im | output | W | Imaginary part of the result, signed |
| out_valid | output | 1 | Results are valid; set by the first frame's first result |
| out_sof | output | 1 | High with output position 0 of each frame |

## Verification
The difficult case is the hand-over between frames. The first butterfly sends out the stored differences of one frame while it loads the first half of the next frame, so a fault there appears only when frames run back to back. The stimulus therefore sends seven frames of different kinds with no gaps: impulses, constants, an alternating sequence and a shifted impulse. Every result of every frame is compared against a DFT that the bench computes with real arithmetic. Nonzero data is sent before the first frame start, so any leakage from the feedback registers into the first frame, or an early out_valid, would be detected.

// File: rtl/fft16_r22sdf.sv
module fft16_r22sdf #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_start,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im,
  output logic                out_valid,
  output logic                out_sof
);
  localparam int N  = 16;
  localparam int LG = $clog2(N);
  localparam int CW = 16;
  localparam int CF = CW - 2;
  localparam int PW = W + CW + 1;

  logic [LG-1:0] cnt_q, cnt;
  logic          run_q, frame_end;
  logic signed [W-1:0] sin_re [LG];
  logic signed [W-1:0] sin_im [LG];
  logic signed [W-1:0] sout_re [LG];
  logic signed [W-1:0] sout_im [LG];

  assign cnt       = in_start ? '0 : cnt_q;
  assign frame_end = (run_q | in_start) && (cnt == '1);

  generate
    for (genvar s = 0; s < LG; s++) begin : g_st
      localparam int D = N >> (s + 1);
      logic signed [W-1:0] dl_re [D];
      logic signed [W-1:0] dl_im [D];
      logic signed [W:0]   xr, xi;
      logic signed [W+1:0] sr, si, dr, di;
      logic sel, rot;

      assign sel = cnt[LG-1-s];
      if (s % 2 == 1) begin : g_rot
        assign rot = sel & ~cnt[LG-s];
      end else begin : g_plain
        assign rot = 1'b0;
      end

      always_comb begin
        xr = rot ? {sin_im[s][W-1], sin_im[s]} : {sin_re[s][W-1], sin_re[s]};
        xi = rot ? -{sin_re[s][W-1], sin_re[s]} : {sin_im[s][W-1], sin_im[s]};
        sr = {dl_re[D-1][W-1], dl_re[D-1][W-1], dl_re[D-1]} + {xr[W], xr};
        si = {dl_im[D-1][W-1], dl_im[D-1][W-1], dl_im[D-1]} + {xi[W], xi};
        dr = {dl_re[D-1][W-1], dl_re[D-1][W-1], dl_re[D-1]} - {xr[W], xr};
        di = {dl_im[D-1][W-1], dl_im[D-1][W-1], dl_im[D-1]} - {xi[W], xi};
      end

      assign sout_re[s] = sel ? W'(sr >>> 1) : dl_re[D-1];
      assign sout_im[s] = sel ? W'(si >>> 1) : dl_im[D-1];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < D; j++) begin
            dl_re[j] <= '0;
            dl_im[j] <= '0;
          end
        end else begin
          dl_re[0] <= sel ? W'(dr >>> 1) : sin_re[s];
          dl_im[0] <= sel ? W'(di >>> 1) : sin_im[s];
          for (int j = 1; j < D; j++) begin
            dl_re[j] <= dl_re[j-1];
            dl_im[j] <= dl_im[j-1];
          end
        end
      end
    end
  endgenerate

  logic [1:0] tm, tq;
  logic [3:0] te;
  logic signed [CW-1:0] tc, ts;
  logic signed [PW-1:0] ar, ai, cc, ss, pr, pi;

  assign tm = cnt[1:0];
  assign tq = cnt[3:2] + 2'd1;
  assign te = {2'b00, tm} * {2'b00, tq[0], tq[1]};

  always_comb begin
    case (te)
      4'd1:    begin tc = 16'sd15137;  ts = 16'sd6270;   end
      4'd2:    begin tc = 16'sd11585;  ts = 16'sd11585;  end
      4'd3:    begin tc = 16'sd6270;   ts = 16'sd15137;  end
      4'd4:    begin tc = 16'sd0;      ts = 16'sd16384;  end
      4'd6:    begin tc = -16'sd11585; ts = 16'sd11585;  end
      4'd9:    begin tc = -16'sd15137; ts = -16'sd6270;  end
      default: begin tc = 16'sd16384;  ts = 16'sd0;      end
    endcase
  end

  assign ar = PW'(sout_re[1]);
  assign ai = PW'(sout_im[1]);
  assign cc = PW'(tc);
  assign ss = PW'(ts);
  assign pr = ar * cc + ai * ss;
  assign pi = ai * cc - ar * ss;

  assign sin_re[0] = in_re;
  assign sin_im[0] = in_im;
  assign sin_re[1] = sout_re[0];
  assign sin_im[1] = sout_im[0];
  assign sin_re[2] = W'(pr >>> CF);
  assign sin_im[2] = W'(pi >>> CF);
  assign sin_re[3] = sout_re[2];
  assign sin_im[3] = sout_im[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      cnt_q     <= cnt + 1'b1;
      run_q     <= run_q | in_start;
      out_re    <= sout_re[LG-1];
      out_im    <= sout_im[LG-1];
      out_sof   <= frame_end;
      out_valid <= out_valid | frame_end;
    end
  end

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sof && out_re == '0 && out_im == '0));

  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  a_r6_valid_rises_with_sof: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sof);

  a_r7_sof_inside_valid: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
endmodule

// File: tb/fft16_r22sdf_tb.sv
module fft16_r22sdf_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W  = 16;
  localparam int NF = 7;
  localparam int NT = NF * 16;
  // columns: kind (0..15 impulse position, 16 constant, 17 alternating), re, im, tolerance
  localparam int TAB [NF][4] = '{
    '{0,   1600,     0, 0},
    '{16,  -800,   400, 0},
    '{3,   1600,  -800, 4},
    '{17, -2000,  1000, 0},
    '{16, 32767,     0, 0},
    '{13, -1200,  2000, 4},
    '{16,     0,     0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_start = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic signed [W-1:0] out_re, out_im;
  logic out_valid, out_sof;

  int checks = 0;
  int failures = 0;
  int xr [NT];
  int xi [NT];
  real er [NT];
  real ei [NT];

  always #2 clk = ~clk;

  fft16_r22sdf #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_start(in_start), .in_re(in_re), .in_im(in_im),
    .out_re(out_re), .out_im(out_im), .out_valid(out_valid), .out_sof(out_sof)
  );

  function automatic string frame_tag(int f);
    case (TAB[f][0])
      16: return (TAB[f][1] == 32767) ? "R4" : ((f == NF - 1) ? "R7" : "R3");
      17: return "R9";
      0:  return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check_bit(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_val(int act, real exp, int tol, string tag, string what);
    real d;
    checks++;
    d = $itor(act) - exp;
    if (d < 0.0) d = -d;
    if (d > $itor(tol) + 0.01) begin
      failures++;
      $display("FAIL %s (R2 order) %s: actual=%0d expected=%f", tag, what, act, exp);
    end
  endtask

  initial begin
    #(4ns * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      for (int n = 0; n < 16; n++) begin
        int kind = TAB[f][0];
        int i = f * 16 + n;
        if (kind == 16) begin
          xr[i] = TAB[f][1]; xi[i] = TAB[f][2];
        end else if (kind == 17) begin
          xr[i] = (n % 2 == 0) ? TAB[f][1] : -TAB[f][1];
          xi[i] = (n % 2 == 0) ? TAB[f][2] : -TAB[f][2];
        end else begin
          xr[i] = (n == kind) ? TAB[f][1] : 0;
          xi[i] = (n == kind) ? TAB[f][2] : 0;
        end
      end
      for (int k = 0; k < 16; k++) begin
        real sre = 0.0, sim = 0.0;
        for (int n = 0; n < 16; n++) begin
          real th = 2.0 * 3.14159265358979 * $itor(n * k) / 16.0;
          sre += $itor(xr[f*16+n]) * $cos(th) + $itor(xi[f*16+n]) * $sin(th);
          sim += $itor(xi[f*16+n]) * $cos(th) - $itor(xr[f*16+n]) * $sin(th);
        end
        er[f*16+k] = sre / 16.0;
        ei[f*16+k] = sim / 16.0;
      end
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R1", "out_valid after reset");
    check_bit(out_sof, 1'b0, "R1", "out_sof after reset");
    check_val(int'(out_re), 0.0, 0, "R1", "out_re after reset");
    check_val(int'(out_im), 0.0, 0, "R1", "out_im after reset");

    // data with no frame start: nothing may become valid
    for (int c = 0; c < 24; c++) begin
      in_re = 16'(1000 + 37 * c);
      in_im = 16'(-500 + 91 * c);
      @(negedge clk);
      check_bit(out_valid, 1'b0, "R6", "out_valid before first start");
    end

    for (int s = 0; s < NT + 16; s++) begin
      if (s > 0) @(negedge clk);
      check_bit(out_valid, (s >= 16), "R6", $sformatf("out_valid at step %0d", s));
      check_bit(out_sof, (s >= 16) && ((s - 16) % 16 == 0), (s == 16) ? "R5" : "R7",
                $sformatf("out_sof at step %0d", s));
      if (s >= 16 && s - 16 < NT) begin
        int o = s - 16;
        int f = o / 16;
        logic [3:0] kk = 4'(o % 16);
        int b = int'({kk[0], kk[1], kk[2], kk[3]});
        check_val(int'(out_re), er[f*16+b], TAB[f][3], frame_tag(f),
                  $sformatf("frame %0d bin %0d re", f, b));
        check_val(int'(out_im), ei[f*16+b], TAB[f][3], frame_tag(f),
                  $sformatf("frame %0d bin %0d im", f, b));
      end
      in_start = (s % 16 == 0);
      in_re = (s < NT) ? 16'(xr[s]) : '0;
      in_im = (s < NT) ? 16'(xi[s]) : '0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule